// File: doc/BRIEF.md
# Serial Flash Erase Sequencer

This block turns one host request (a start address and a byte length) into the complete series of commands that erases that range on an SPI NOR flash. It first validates the request. For each erase unit it then runs three steps. It polls the flash status until the write-in-progress bit reads clear. It sends a write-enable command. It sends the erase command carrying the 24-bit unit address. Each command travels in its own chip-select frame over a byte-level transaction port, and a separate serializer outside the block handles the individual bits.

The host supplies the device size and the unit choice: a small-unit enable that selects 4 KiB units, or the log2 of the device's native sector size. The block raises `busy` for the whole sequence and pulses `done` when it finishes. If the request is rejected or a status poll times out, it also sets a sticky `fail` flag.

Top module: `flash_erase_seq`

## Requirements
- R1: A request with `req_start + req_len > dev_size` is rejected: no frame is issued, `done` pulses and `fail` is 1 in the same cycle, and `busy` stays low.
- R2: A request whose start or length is not a multiple of the unit size is rejected in the same way as R1.
- R3: With `small_unit_en`=1 the unit is 4096 bytes and the erase opcode is 0x20. With `small_unit_en`=0 the unit is 2^`native_unit_log2` bytes and the opcode is 0xD8.
- R4: Before every erase unit the block issues status frames. Each is 2 bytes: opcode 0x05, then a filler byte whose response is the status. It repeats them until bit 0 of the response is 0, and other status bits are ignored.
- R5: If MAX_POLLS consecutive status frames for one unit all read bit 0 = 1, the sequence stops at once. No further unit is issued, and `done` and `fail` are raised.
- R6: Immediately before each erase frame the block sends a one-byte write-enable frame containing opcode 0x06.
- R7: The erase frame is exactly 4 bytes: the opcode, then address bits 23:16, 15:8 and 7:0.
- R8: Unit k of an accepted request is erased at `req_start + k*unit`, for k from 0 to `req_len/unit - 1`. A zero-length request completes with `done`, no frames and `fail`=0.
- R9: `done` is a one-cycle pulse. `fail` holds its value while idle and is cleared when the next request is accepted.
- R10: `busy` is high for every cycle of an accepted sequence, including every frame, and low when `done` pulses. A request presented while `busy` is high is ignored.
- R11: `spi_tx` holds steady while `spi_go` is high and `spi_ack` is low. Chip select returns low for at least one cycle between any two frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle request strobe, sampled while idle |
| req_start | input | 24 | First byte address of the range |
| req_len | input | 25 | Length of the range in bytes |
| dev_size | input | 25 | Device capacity in bytes |
| small_unit_en | input | 1 | 1: 4 KiB units with opcode 0x20; 0: native sector with opcode 0xD8 |
| native_unit_log2 | input | 5 | log2 of the native sector size |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Sticky failure flag |
| spi_cs | output | 1 | Chip-select frame, high while a command is in flight |
| spi_go | output | 1 | Byte transfer request |
| spi_tx | output | 8 | Byte to transmit |
| spi_ack | input | 1 | Byte transferred; `spi_rx` valid |
| spi_rx | input | 8 | Byte received during that transfer |

## Verification
The hardest case to reach is a poll timeout that falls in the middle of a multi-unit request. The first unit must succeed, and only the following unit may see a flash that never goes idle. The bench's flash model keeps the busy bit set for a programmable number of status reads after each erase frame. The bench sets that count far above a reduced MAX_POLLS, so the first unit erases normally and the second unit times out. The exact count of status frames then pins the timeout boundary, and the single recorded erase proves that the sequence stopped immediately.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;
  localparam int ADDR_W = 24;
  localparam int LEN_W  = ADDR_W + 1;

  localparam logic [7:0] OP_STATUS  = 8'h05;
  localparam logic [7:0] OP_WR_EN   = 8'h06;
  localparam logic [7:0] OP_ER_SMALL = 8'h20;
  localparam logic [7:0] OP_ER_NATIVE = 8'hD8;
  localparam int SMALL_LOG2 = 12;

  typedef enum logic [1:0] {ST_IDLE, ST_FRAME, ST_GAP} seq_state_t;
  typedef enum logic [1:0] {K_STATUS, K_WREN, K_ERASE} cmd_kind_t;
endpackage

// File: rtl/erase_req_check.sv
module erase_req_check
  import flash_erase_pkg::*;
(
  input  logic [ADDR_W-1:0] start,
  input  logic [LEN_W-1:0]  len,
  input  logic [LEN_W-1:0]  dev_size,
  input  logic              small_en,
  input  logic [4:0]        native_log2,
  output logic [LEN_W-1:0]  unit_bytes,
  output logic [7:0]        erase_op,
  output logic              reject
);
  logic [LEN_W:0]   span_end;
  logic [LEN_W-1:0] mask;

  always_comb begin
    unit_bytes = small_en ? (LEN_W'(1) << SMALL_LOG2) : (LEN_W'(1) << native_log2);
    erase_op   = small_en ? OP_ER_SMALL : OP_ER_NATIVE;
    mask       = unit_bytes - LEN_W'(1);
    span_end   = {2'b00, start} + {1'b0, len};
    reject     = (span_end > {1'b0, dev_size})
               || ((LEN_W'(start) & mask) != '0)
               || ((len & mask) != '0);
  end
endmodule

// File: rtl/erase_cmd_bytes.sv
module erase_cmd_bytes
  import flash_erase_pkg::*;
(
  input  cmd_kind_t         kind,
  input  logic [1:0]        idx,
  input  logic [7:0]        erase_op,
  input  logic [ADDR_W-1:0] addr,
  output logic [7:0]        tx_byte,
  output logic [1:0]        last_idx
);
  always_comb begin
    tx_byte  = 8'h00;
    last_idx = 2'd0;
    unique case (kind)
      K_STATUS: begin
        last_idx = 2'd1;
        tx_byte  = (idx == 2'd0) ? OP_STATUS : 8'h00;
      end
      K_WREN: begin
        last_idx = 2'd0;
        tx_byte  = OP_WR_EN;
      end
      default: begin
        last_idx = 2'd3;
        case (idx)
          2'd0:    tx_byte = erase_op;
          2'd1:    tx_byte = addr[23:16];
          2'd2:    tx_byte = addr[15:8];
          default: tx_byte = addr[7:0];
        endcase
      end
    endcase
  end
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import flash_erase_pkg::*;
#(
  parameter int MAX_POLLS = 100000
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  input  logic [23:0]            req_start,
  input  logic [24:0]            req_len,
  input  logic [24:0]            dev_size,
  input  logic                   small_unit_en,
  input  logic [4:0]             native_unit_log2,
  output logic                   busy,
  output logic                   done,
  output logic                   fail,
  output logic                   spi_cs,
  output logic                   spi_go,
  output logic [7:0]             spi_tx,
  input  logic                   spi_ack,
  input  logic [7:0]             spi_rx
);
  localparam int PCNT_W = $clog2(MAX_POLLS + 1);

  seq_state_t        st;
  cmd_kind_t         kind;
  logic [1:0]        idx;
  logic [1:0]        last_idx;
  logic [ADDR_W-1:0] addr;
  logic [LEN_W-1:0]  remain;
  logic [LEN_W-1:0]  unit_q;
  logic [7:0]        op_q;
  logic [PCNT_W-1:0] polls;
  logic              flash_busy;

  logic [LEN_W-1:0]  unit_in;
  logic [7:0]        op_in;
  logic              reject;

  erase_req_check u_check (
    .start       (req_start),
    .len         (req_len),
    .dev_size    (dev_size),
    .small_en    (small_unit_en),
    .native_log2 (native_unit_log2),
    .unit_bytes  (unit_in),
    .erase_op    (op_in),
    .reject      (reject)
  );

  erase_cmd_bytes u_bytes (
    .kind     (kind),
    .idx      (idx),
    .erase_op (op_q),
    .addr     (addr),
    .tx_byte  (spi_tx),
    .last_idx (last_idx)
  );

  assign busy   = (st != ST_IDLE);
  assign spi_cs = (st == ST_FRAME);
  assign spi_go = (st == ST_FRAME);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      kind       <= K_STATUS;
      idx        <= '0;
      addr       <= '0;
      remain     <= '0;
      unit_q     <= '0;
      op_q       <= '0;
      polls      <= '0;
      flash_busy <= 1'b0;
      done       <= 1'b0;
      fail       <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (req_valid) begin
            if (reject) begin
              fail <= 1'b1;
              done <= 1'b1;
            end else if (req_len == '0) begin
              fail <= 1'b0;
              done <= 1'b1;
            end else begin
              fail   <= 1'b0;
              addr   <= req_start;
              remain <= req_len;
              unit_q <= unit_in;
              op_q   <= op_in;
              kind   <= K_STATUS;
              idx    <= '0;
              polls  <= '0;
              st     <= ST_FRAME;
            end
          end
        end
        ST_FRAME: begin
          if (spi_ack) begin
            if (kind == K_STATUS && idx == 2'd1) flash_busy <= spi_rx[0];
            if (idx == last_idx) st  <= ST_GAP;
            else                 idx <= idx + 2'd1;
          end
        end
        default: begin
          idx <= '0;
          st  <= ST_FRAME;
          unique case (kind)
            K_STATUS: begin
              if (!flash_busy) begin
                kind <= K_WREN;
              end else if (polls == PCNT_W'(MAX_POLLS - 1)) begin
                fail <= 1'b1;
                done <= 1'b1;
                st   <= ST_IDLE;
              end else begin
                polls <= polls + PCNT_W'(1);
              end
            end
            K_WREN: kind <= K_ERASE;
            default: begin
              addr   <= addr + unit_q[ADDR_W-1:0];
              remain <= remain - unit_q;
              polls  <= '0;
              kind   <= K_STATUS;
              if (remain == unit_q) begin
                done <= 1'b1;
                st   <= ST_IDLE;
              end
            end
          endcase
        end
      endcase
    end
  end
endmodule

// File: rtl/flash_erase_seq_chk.sv
module flash_erase_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic       busy,
  input logic       done,
  input logic       fail,
  input logic       spi_go,
  input logic       spi_ack,
  input logic [7:0] spi_tx
);
  assert_hold_byte_R11: assert property (@(posedge clk) disable iff (rst)
    (spi_go && !spi_ack) |=> (spi_go && $stable(spi_tx)));

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_fail_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (!busy && !req_valid) |=> $stable(fail));

  assert_fail_cleared_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !fail);
endmodule

bind flash_erase_seq flash_erase_seq_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .busy      (busy),
  .done      (done),
  .fail      (fail),
  .spi_go    (spi_go),
  .spi_ack   (spi_ack),
  .spi_tx    (spi_tx)
);

// File: tb/test_flash_erase_seq.sv
`timescale 1ns/1ps
module test_flash_erase_seq;
  localparam int POLLS = 8;
  localparam logic [24:0] DEV = 25'h0100000;

  logic clk = 0, rst = 1;
  logic req_valid = 0;
  logic [23:0] req_start = 0;
  logic [24:0] req_len = 0;
  logic small_en = 1;
  logic busy, done, fail, spi_cs, spi_go, spi_ack;
  logic [7:0] spi_tx, spi_rx;

  always #5 clk = ~clk;

  flash_erase_seq #(.MAX_POLLS(POLLS)) i_flash_erase_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_start(req_start),
    .req_len(req_len), .dev_size(DEV), .small_unit_en(small_en),
    .native_unit_log2(5'd16), .busy(busy), .done(done), .fail(fail),
    .spi_cs(spi_cs), .spi_go(spi_go), .spi_tx(spi_tx),
    .spi_ack(spi_ack), .spi_rx(spi_rx));

  // flash model
  logic model_clear = 0;
  int   busy_cfg = 0;
  int   busy_left, n_stat, n_wren, n_erase, n_shape, n_order, n_busyviol, fb_n;
  logic [7:0] fb [4];
  logic [23:0] er_addr [16];
  logic [7:0]  er_op [16];
  logic cs_q, wren_seen;

  always @(posedge clk) begin
    if (model_clear) begin
      busy_left <= 0; n_stat <= 0; n_wren <= 0; n_erase <= 0; n_shape <= 0;
      n_order <= 0; n_busyviol <= 0; fb_n <= 0; cs_q <= 0; wren_seen <= 0;
      spi_ack <= 0; spi_rx <= 0;
    end else begin
      cs_q <= spi_cs;
      if (spi_cs && !busy) n_busyviol <= n_busyviol + 1;
      if (spi_go && !spi_ack) begin
        spi_ack <= 1;
        if (fb_n < 4) fb[fb_n] <= spi_tx;
        fb_n <= fb_n + 1;
        if (fb_n == 1 && fb[0] == 8'h05) begin
          spi_rx <= (busy_left != 0) ? 8'hFF : 8'hFE;
          if (busy_left != 0) busy_left <= busy_left - 1;
        end else spi_rx <= 8'h00;
      end else spi_ack <= 0;
      if (cs_q && !spi_cs) begin
        fb_n <= 0;
        if (fb[0] == 8'h05 && fb_n == 2) begin n_stat <= n_stat + 1; wren_seen <= 0; end
        else if (fb[0] == 8'h06 && fb_n == 1) begin n_wren <= n_wren + 1; wren_seen <= 1; end
        else if ((fb[0] == 8'h20 || fb[0] == 8'hD8) && fb_n == 4) begin
          if (!wren_seen) n_order <= n_order + 1;
          wren_seen <= 0;
          if (n_erase < 16) begin
            er_addr[n_erase] <= {fb[1], fb[2], fb[3]};
            er_op[n_erase]   <= fb[0];
          end
          n_erase <= n_erase + 1;
          busy_left <= busy_cfg;
        end else n_shape <= n_shape + 1;
      end
    end
  end

  int total = 0, bad = 0;

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_model(input int bc);
    @(negedge clk); busy_cfg = bc; model_clear = 1;
    @(negedge clk); model_clear = 0;
  endtask

  task automatic pulse_req(input logic [23:0] s, input logic [24:0] l, input logic sm);
    @(negedge clk);
    req_start = s; req_len = l; small_en = sm; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
  endtask

  // waits until done is seen at a negedge; returns 1 if seen
  task automatic wait_done(output logic seen, output logic saw_busy_at_done);
    seen = 0; saw_busy_at_done = 0;
    if (done) begin seen = 1; saw_busy_at_done = busy; return; end
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (done) begin seen = 1; saw_busy_at_done = busy; break; end
    end
  endtask

  // vector: start, len, small, expect fail, units
  localparam int NV = 9;
  localparam logic [63:0] VEC [NV] = '{
    {24'h000000, 25'h0001000, 1'b1, 1'b0, 8'd1, 5'd0},
    {24'h003000, 25'h0003000, 1'b1, 1'b0, 8'd3, 5'd0},
    {24'h010000, 25'h0020000, 1'b0, 1'b0, 8'd2, 5'd0},
    {24'h001000, 25'h0001000, 1'b0, 1'b1, 8'd0, 5'd0},
    {24'h0FF000, 25'h0002000, 1'b1, 1'b1, 8'd0, 5'd0},
    {24'h000800, 25'h0001000, 1'b1, 1'b1, 8'd0, 5'd0},
    {24'h0FF000, 25'h0001000, 1'b1, 1'b0, 8'd1, 5'd0},
    {24'h000000, 25'h0001800, 1'b1, 1'b1, 8'd0, 5'd0},
    {24'h002000, 25'h0000000, 1'b1, 1'b0, 8'd0, 5'd0}
  };

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic seen, bz;
    model_clear = 1;
    repeat (3) @(negedge clk);
    rst = 0; model_clear = 0;
    @(negedge clk);
    chk(!busy && !done && !fail && !spi_cs && !spi_go, "reset state R9 R10",
        {busy, done, fail, spi_cs}, 0);

    for (int v = 0; v < NV; v++) begin
      logic [23:0] s;
      logic [24:0] l;
      logic sm, ef;
      int units, unit, exp_stat, addr_bad;
      s = VEC[v][63:40]; l = VEC[v][39:15]; sm = VEC[v][14]; ef = VEC[v][13];
      units = int'(VEC[v][12:5]);
      unit = sm ? 4096 : 65536;
      clear_model(2);
      pulse_req(s, l, sm);
      wait_done(seen, bz);
      chk(seen && !bz, $sformatf("vec%0d done with busy low R10 R9", v), {seen, bz}, 2'b10);
      chk(fail == ef, $sformatf("vec%0d fail flag R1 R2", v), fail, ef);
      @(negedge clk);
      chk(n_erase == units, $sformatf("vec%0d erase count R8", v), n_erase, units);
      chk(n_wren == units && n_order == 0, $sformatf("vec%0d write-enable before erase R6", v),
          n_wren, units);
      exp_stat = (units == 0) ? 0 : 1 + (units - 1) * 3;
      chk(n_stat == exp_stat, $sformatf("vec%0d status polls R4", v), n_stat, exp_stat);
      chk(n_shape == 0 && n_busyviol == 0, $sformatf("vec%0d frame shape R7 R11 R10", v),
          n_shape, 0);
      addr_bad = 0;
      for (int k = 0; k < units; k++) begin
        if (er_addr[k] != s + 24'(k * unit)) addr_bad++;
        if (er_op[k] != (sm ? 8'h20 : 8'hD8)) addr_bad++;
      end
      chk(addr_bad == 0, $sformatf("vec%0d addresses and opcode R3 R7 R8", v), addr_bad, 0);
      @(negedge clk);
      chk(fail == ef, $sformatf("vec%0d fail holds while idle R9", v), fail, ef);
    end

    // timeout in second unit
    clear_model(1000);
    pulse_req(24'h000000, 25'h0002000, 1'b1);
    wait_done(seen, bz);
    chk(seen && fail, "timeout raises fail R5", {seen, fail}, 2'b11);
    @(negedge clk);
    chk(n_erase == 1, "timeout stops at once R5", n_erase, 1);
    chk(n_stat == 1 + POLLS, "timeout after MAX_POLLS polls R5", n_stat, 1 + POLLS);
    repeat (10) @(negedge clk);
    chk(fail && !busy, "fail sticky until next request R9", fail, 1);

    // next request clears fail
    clear_model(0);
    pulse_req(24'h004000, 25'h0001000, 1'b1);
    chk(!fail && busy, "fail cleared on accept R9", {fail, busy}, 2'b01);
    wait_done(seen, bz);
    chk(seen && !fail, "clean request after failure R9", fail, 0);

    // request while busy is ignored
    clear_model(2);
    pulse_req(24'h008000, 25'h0002000, 1'b1);
    repeat (15) @(negedge clk);
    chk(busy, "busy held mid-sequence R10", busy, 1);
    pulse_req(24'h080000, 25'h0001000, 1'b0);
    wait_done(seen, bz);
    @(negedge clk);
    chk(n_erase == 2 && er_addr[0] == 24'h008000 && er_addr[1] == 24'h009000 && er_op[1] == 8'h20,
        "request while busy ignored R10", er_addr[1], 24'h009000);
    repeat (5) @(negedge clk);
    chk(n_erase == 2 && !busy, "no late sequence from ignored request R10", n_erase, 2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule